// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block brings a DDR3 device from power-on to a state in which it accepts ordinary traffic. After a synchronous reset it holds the memory's reset pin low, releases it, keeps the clock enable low for a further interval, and then raises clock enable. It then issues the fixed start-up command series. That series is three mode-register writes, a long ZQ calibration, a precharge of every bank and one refresh. Each command is placed a set number of clocks after the one before it.

Every wait is a clock count set by a parameter. The mode-register words are computed during elaboration from the CAS latency, CAS write latency and write-recovery parameters. After the refresh interval has passed, a done flag rises and stays high until the next synchronous reset. The memory controller selects its command pins from this block until that flag goes high.

Top module: `ddr3_init_seq`

## Requirements
- R1: From the clock after a synchronous reset is removed (cycle 0), the memory reset pin is low and clock enable is low for exactly T_RESET cycles. While the synchronous reset is asserted, the pins show the same values.
- R2: The memory reset pin then goes high and clock enable stays low for exactly T_CKE more cycles. Clock enable then rises and stays high until the next synchronous reset.
- R3: Exactly T_XPR cycles after clock enable rises, a mode-register write is issued (CS_n, RAS_n, CAS_n and WE_n all low) with bank 2 and address 0x40 | (((CWL-5)&7)<<3).
- R4: Exactly T_MRD cycles after that, a mode-register write to bank 1 with address 0x044 is issued.
- R5: Exactly T_MRD cycles after that, a mode-register write to bank 0 is issued. Its address is ((CL-4)&7)<<4, plus bit 2 when CL>11, plus a write-recovery code in bits 11:9. The code is tWR-4 for tWR 5 to 7, tWR/2 for even tWR 8 to 14, and 0 for tWR 16.
- R6: Exactly T_MOD cycles after the bank-0 write, a long ZQ calibration is issued (CS_n low, RAS_n high, CAS_n high, WE_n low) with address 0x400 and bank 0.
- R7: Exactly T_ZQ cycles after the calibration, a precharge is issued (CS_n low, RAS_n low, CAS_n high, WE_n low) with address 0x400. Exactly T_RP cycles later, a refresh is issued (CS_n, RAS_n, CAS_n low, WE_n high) with address 0.
- R8: In every other cycle the pins carry a NOP (CS_n low, RAS_n, CAS_n and WE_n high) with bank 0 and address 0.
- R9: The done flag rises exactly T_RFC+2 cycles after the refresh cycle. While it is high, only NOPs appear, and it stays high until a synchronous reset.
- R10: A synchronous reset at any point of the sequence, including after done, restarts the sequence from cycle 0 of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high; restarts the sequence |
| ddr_reset_n | output | 1 | Memory reset pin, active low |
| ddr_cke | output | 1 | Memory clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BA_W | Bank address |
| ddr_addr | output | ADDR_W | Row/mode address bus |
| init_done | output | 1 | Initialization finished; memory may take traffic |

## Verification
The bench compares every pin in every cycle against a cycle-indexed model built from the requirements. Complete sequences show that each command lands on its exact cycle with the right encoding, bank and address, and that the NOP gaps between commands are clean. Resets at randomly chosen cycles show that restarting from any state, including mid-gap and after done, returns to the reset-pin-low phase with a fresh count. A second instance with a high CAS latency and the largest write recovery shows that the latency-above-eleven bit and the zero write-recovery code reach the mode words, which the first instance's typical values cannot show.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

   typedef enum logic [3:0] {
      ST_RST, ST_CKE_LO, ST_XPR, ST_MR2, ST_GAP_A, ST_MR1, ST_GAP_B, ST_MR0,
      ST_GAP_MOD, ST_ZQ, ST_GAP_ZQ, ST_PRE, ST_GAP_RP, ST_REF, ST_GAP_RFC, ST_DONE
   } seq_state_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_pins_t;

   localparam cmd_pins_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam cmd_pins_t CMD_MRS  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
   localparam cmd_pins_t CMD_ZQCL = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};
   localparam cmd_pins_t CMD_PRE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
   localparam cmd_pins_t CMD_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // write-recovery code placed in bits 11:9 of the bank-0 mode word
   function automatic logic [2:0] wr_code(input int twr);
      if (twr == 16)     return 3'd0;
      else if (twr >= 8) return 3'(twr / 2);
      else               return 3'(twr - 4);
   endfunction

   function automatic logic [15:0] mode0_word(input int cl, input int twr);
      logic [15:0] w;
      w = 16'((cl - 4) & 7) << 4;
      if (cl > 11) w = w | 16'h0004;
      w = w | (16'(wr_code(twr)) << 9);
      return w;
   endfunction

   function automatic logic [15:0] mode2_word(input int cwl);
      return 16'h0040 | (16'((cwl - 5) & 7) << 3);
   endfunction

endpackage

// File: rtl/ddr3_init_mrcalc.sv
module ddr3_init_mrcalc
   import ddr3_init_pkg::*;
#(
   parameter int CL     = 5,
   parameter int CWL    = 5,
   parameter int TWR    = 5,
   parameter int ADDR_W = 14
) (
   output logic [ADDR_W-1:0] mr0_val,
   output logic [ADDR_W-1:0] mr1_val,
   output logic [ADDR_W-1:0] mr2_val
);

   localparam logic [15:0] MR0_W = mode0_word(CL, TWR);
   localparam logic [15:0] MR2_W = mode2_word(CWL);
   localparam logic [15:0] MR1_W = 16'h0044;

   if (CL < 5 || CL > 16) begin : g_bad_cl
      $error("ddr3_init_mrcalc: CL out of range");
   end
   if (CWL < 5 || CWL > 12) begin : g_bad_cwl
      $error("ddr3_init_mrcalc: CWL out of range");
   end
   if (!(TWR == 5 || TWR == 6 || TWR == 7 || TWR == 8 || TWR == 10 ||
         TWR == 12 || TWR == 14 || TWR == 16)) begin : g_bad_twr
      $error("ddr3_init_mrcalc: unsupported write recovery");
   end

   if (ADDR_W >= 16) begin : g_wide
      assign mr0_val = ADDR_W'(MR0_W);
      assign mr1_val = ADDR_W'(MR1_W);
      assign mr2_val = ADDR_W'(MR2_W);
   end else begin : g_narrow
      assign mr0_val = MR0_W[ADDR_W-1:0];
      assign mr1_val = MR1_W[ADDR_W-1:0];
      assign mr2_val = MR2_W[ADDR_W-1:0];
   end

endmodule

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
   import ddr3_init_pkg::*;
#(
   parameter int ADDR_W  = 14,
   parameter int BA_W    = 3,
   parameter int CL      = 5,
   parameter int CWL     = 5,
   parameter int TWR     = 5,
   parameter int T_RESET = 64000,
   parameter int T_CKE   = 160000,
   parameter int T_XPR   = 56,
   parameter int T_MRD   = 4,
   parameter int T_MOD   = 12,
   parameter int T_ZQ    = 512,
   parameter int T_RP    = 5,
   parameter int T_RFC   = 52
) (
   input  logic              clk,
   input  logic              rst,
   output logic              ddr_reset_n,
   output logic              ddr_cke,
   output logic              ddr_cs_n,
   output logic              ddr_ras_n,
   output logic              ddr_cas_n,
   output logic              ddr_we_n,
   output logic [BA_W-1:0]   ddr_ba,
   output logic [ADDR_W-1:0] ddr_addr,
   output logic              init_done
);

   localparam int MAX_WAIT = max_of(max_of(max_of(T_RESET, T_CKE), max_of(T_XPR, T_ZQ)),
                                    max_of(max_of(T_MRD, T_MOD), max_of(T_RP, T_RFC + 1)));
   localparam int CNT_W = $clog2(MAX_WAIT + 1);
   localparam logic [ADDR_W-1:0] A10 = ADDR_W'(1) << 10;

   localparam logic [CNT_W-1:0] LD_RESET = CNT_W'(T_RESET - 1);
   localparam logic [CNT_W-1:0] LD_CKE   = CNT_W'(T_CKE - 1);
   localparam logic [CNT_W-1:0] LD_XPR   = CNT_W'(T_XPR - 1);
   localparam logic [CNT_W-1:0] LD_MRD   = CNT_W'(T_MRD - 2);
   localparam logic [CNT_W-1:0] LD_MOD   = CNT_W'(T_MOD - 2);
   localparam logic [CNT_W-1:0] LD_ZQ    = CNT_W'(T_ZQ - 2);
   localparam logic [CNT_W-1:0] LD_RP    = CNT_W'(T_RP - 2);
   localparam logic [CNT_W-1:0] LD_RFC   = CNT_W'(T_RFC);

   if (ADDR_W < 12 || BA_W < 2) begin : g_bad_bus
      $error("ddr3_init_seq: address or bank bus too narrow");
   end
   if (T_RESET < 1 || T_CKE < 1 || T_XPR < 1 || T_MRD < 2 || T_MOD < 2 ||
       T_ZQ < 2 || T_RP < 2 || T_RFC < 0) begin : g_bad_timing
      $error("ddr3_init_seq: timing parameter below minimum");
   end

   seq_state_e       state_q, state_d;
   logic             advance, tmr_load, tmr_zero;
   logic [CNT_W-1:0] tmr_val;
   logic [ADDR_W-1:0] mr0_val, mr1_val, mr2_val;
   cmd_pins_t        cmd;

   ddr3_init_mrcalc #(.CL(CL), .CWL(CWL), .TWR(TWR), .ADDR_W(ADDR_W)) u_mrcalc (
      .mr0_val(mr0_val), .mr1_val(mr1_val), .mr2_val(mr2_val)
   );

   ddr3_init_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .load(tmr_load), .load_val(tmr_val), .expired(tmr_zero)
   );

   // state advance and next-interval selection
   always_comb begin
      state_d = state_q;
      advance = 1'b0;
      unique case (state_q)
         ST_RST, ST_CKE_LO, ST_XPR, ST_GAP_A, ST_GAP_B, ST_GAP_MOD,
         ST_GAP_ZQ, ST_GAP_RP, ST_GAP_RFC: advance = tmr_zero;
         ST_DONE: advance = 1'b0;
         default: advance = 1'b1;
      endcase
      if (advance) state_d = seq_state_e'(state_q + 4'd1);
   end

   always_comb begin
      unique case (state_d)
         ST_CKE_LO:  tmr_val = LD_CKE;
         ST_XPR:     tmr_val = LD_XPR;
         ST_GAP_A,
         ST_GAP_B:   tmr_val = LD_MRD;
         ST_GAP_MOD: tmr_val = LD_MOD;
         ST_GAP_ZQ:  tmr_val = LD_ZQ;
         ST_GAP_RP:  tmr_val = LD_RP;
         ST_GAP_RFC: tmr_val = LD_RFC;
         default:    tmr_val = '0;
      endcase
      if (rst) tmr_val = LD_RESET;
   end

   assign tmr_load = rst | advance;

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_RST;
      else     state_q <= state_d;
   end

   // pin decode
   always_comb begin
      ddr_reset_n = 1'b1;
      ddr_cke     = 1'b1;
      cmd         = CMD_NOP;
      ddr_ba      = '0;
      ddr_addr    = '0;
      init_done   = 1'b0;
      unique case (state_q)
         ST_RST:    begin ddr_reset_n = 1'b0; ddr_cke = 1'b0; end
         ST_CKE_LO: ddr_cke = 1'b0;
         ST_MR2:    begin cmd = CMD_MRS; ddr_ba = BA_W'(2); ddr_addr = mr2_val; end
         ST_MR1:    begin cmd = CMD_MRS; ddr_ba = BA_W'(1); ddr_addr = mr1_val; end
         ST_MR0:    begin cmd = CMD_MRS; ddr_addr = mr0_val; end
         ST_ZQ:     begin cmd = CMD_ZQCL; ddr_addr = A10; end
         ST_PRE:    begin cmd = CMD_PRE; ddr_addr = A10; end
         ST_REF:    cmd = CMD_REF;
         ST_DONE:   init_done = 1'b1;
         default:   ;
      endcase
   end

   assign ddr_cs_n  = cmd.cs_n;
   assign ddr_ras_n = cmd.ras_n;
   assign ddr_cas_n = cmd.cas_n;
   assign ddr_we_n  = cmd.we_n;

   logic pins_nop;
   assign pins_nop = !ddr_cs_n && ddr_ras_n && ddr_cas_n && ddr_we_n;

   AST_CKE_NEEDS_RESET_HI: assert property (@(posedge clk) disable iff (rst)
      ddr_cke |-> ddr_reset_n);                                   // R2
   AST_CKE_NO_FALL: assert property (@(posedge clk) disable iff (rst)
      !$fell(ddr_cke));                                           // R2
   AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (rst)
      !pins_nop |-> ddr_cke);                                     // R8
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);                                   // R9
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
      init_done |-> (pins_nop && ddr_addr == '0));                // R9

endmodule

// File: tb/ddr3_init_seq_bench.sv
module ddr3_init_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int TR = 20, TC = 30, TX = 8, TM = 4, TMOD = 6, TZQ = 16, TRP = 5, TRFC = 10;
   localparam int P_XPR  = TR + TC;
   localparam int P_MR2  = P_XPR + TX;
   localparam int P_MR1  = P_MR2 + TM;
   localparam int P_MR0  = P_MR1 + TM;
   localparam int P_ZQ   = P_MR0 + TMOD;
   localparam int P_PRE  = P_ZQ + TZQ;
   localparam int P_REF  = P_PRE + TRP;
   localparam int P_DONE = P_REF + TRFC + 2;

   // instance A: CL=6 CWL=6 tWR=10 ; instance B: CL=12 CWL=8 tWR=16
   localparam logic [13:0] MR2_A = 14'h048, MR0_A = 14'hA20;
   localparam logic [13:0] MR2_B = 14'h058, MR0_B = 14'h004;

   logic clk = 1'b0;
   logic rst = 1'b1;
   int vectors = 0, miscompares = 0;
   bit finished = 0;

   logic a_rn, a_cke, a_cs, a_ras, a_cas, a_we, a_done;
   logic [2:0] a_ba;
   logic [13:0] a_addr;
   logic b_rn, b_cke, b_cs, b_ras, b_cas, b_we, b_done;
   logic [2:0] b_ba;
   logic [13:0] b_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   ddr3_init_seq #(.CL(6), .CWL(6), .TWR(10), .T_RESET(TR), .T_CKE(TC), .T_XPR(TX),
      .T_MRD(TM), .T_MOD(TMOD), .T_ZQ(TZQ), .T_RP(TRP), .T_RFC(TRFC)) u_ddr3_init_seq (
      .clk(clk), .rst(rst), .ddr_reset_n(a_rn), .ddr_cke(a_cke), .ddr_cs_n(a_cs),
      .ddr_ras_n(a_ras), .ddr_cas_n(a_cas), .ddr_we_n(a_we), .ddr_ba(a_ba),
      .ddr_addr(a_addr), .init_done(a_done));

   ddr3_init_seq #(.CL(12), .CWL(8), .TWR(16), .T_RESET(TR), .T_CKE(TC), .T_XPR(TX),
      .T_MRD(TM), .T_MOD(TMOD), .T_ZQ(TZQ), .T_RP(TRP), .T_RFC(TRFC)) u_ddr3_init_seq_alt (
      .clk(clk), .rst(rst), .ddr_reset_n(b_rn), .ddr_cke(b_cke), .ddr_cs_n(b_cs),
      .ddr_ras_n(b_ras), .ddr_cas_n(b_cas), .ddr_we_n(b_we), .ddr_ba(b_ba),
      .ddr_addr(b_addr), .init_done(b_done));

   // {reset_n, cke, cs_n, ras_n, cas_n, we_n, ba[2:0], addr[13:0], done}
   function automatic logic [23:0] exp_pins(int k, logic [13:0] mr0, logic [13:0] mr2);
      logic rn = 1'b1, ck = 1'b1, dn = 1'b0;
      logic [3:0] c = 4'b0111;
      logic [2:0] ba = 3'd0;
      logic [13:0] ad = 14'd0;
      if (k < TR)              begin rn = 1'b0; ck = 1'b0; end
      else if (k < P_XPR)      ck = 1'b0;
      else if (k == P_MR2)     begin c = 4'b0000; ba = 3'd2; ad = mr2; end
      else if (k == P_MR1)     begin c = 4'b0000; ba = 3'd1; ad = 14'h044; end
      else if (k == P_MR0)     begin c = 4'b0000; ad = mr0; end
      else if (k == P_ZQ)      begin c = 4'b0110; ad = 14'h400; end
      else if (k == P_PRE)     begin c = 4'b0010; ad = 14'h400; end
      else if (k == P_REF)     c = 4'b0001;
      else if (k >= P_DONE)    dn = 1'b1;
      return {rn, ck, c, ba, ad, dn};
   endfunction

   function automatic string req_tag(int k);
      if (k < TR)            return "R1";
      if (k < P_XPR)         return "R2";
      if (k == P_MR2)        return "R3";
      if (k == P_MR1)        return "R4";
      if (k == P_MR0)        return "R5";
      if (k == P_ZQ)         return "R6";
      if (k == P_PRE || k == P_REF) return "R7";
      if (k >= P_DONE)       return "R9";
      return "R8";
   endfunction

   task automatic check_cycle(int k, bit restart);
      logic [23:0] ga, gb, ea, eb;
      string tag;
      tag = restart ? "R10" : req_tag(k);
      ga = {a_rn, a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_done};
      gb = {b_rn, b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_done};
      ea = exp_pins(k, MR0_A, MR2_A);
      eb = exp_pins(k, MR0_B, MR2_B);
      vectors += 2;
      if (ga !== ea) begin
         miscompares++;
         $display("FAIL %s inst A cycle %0d: actual %h expected %h", tag, k, ga, ea);
      end
      if (gb !== eb) begin
         miscompares++;
         $display("FAIL %s inst B cycle %0d: actual %h expected %h", tag, k, gb, eb);
      end
   endtask

   task automatic run_seq(int len, bit restart);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check_cycle(0, restart);
      rst = 1'b0;
      for (int k = 1; k <= len; k++) begin
         @(negedge clk);
         check_cycle(k, 1'b0);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      int seed_val;
      seed_val = $urandom(32'd1234);
      // R1..R9: complete sequence, including a long done tail
      run_seq(P_DONE + 40, 1'b0);
      // R10: restart after done, then aborts at random points
      run_seq(P_DONE + 5, 1'b1);
      for (int i = 0; i < 14; i++) begin
         run_seq($urandom_range(1, P_DONE + 10), 1'b1);
      end
      // R10 corner cases: abort just before/after each command
      run_seq(P_MR2, 1'b1);
      run_seq(P_MR1 + 1, 1'b1);
      run_seq(P_REF, 1'b1);
      run_seq(P_DONE - 1, 1'b1);
      // R10: final complete run after the aborts
      run_seq(P_DONE + 20, 1'b1);
      if (seed_val < 0) $display("seed %0d", seed_val);
      report();
   end

   initial begin
      #(CLK_PERIOD * 100000);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

endmodule